// File: doc/BRIEF.md
# Grouped Falling-Edge Wakeup Request Collector

This block gathers thirty-two external key-scan and wakeup lines and turns them into four interrupt request lines, one per bank of eight lines. Each line is brought into the clock domain by a synchronizer and watched for a high-to-low transition. A detected transition sets that line's pending latch. A per-line mask bit decides whether the pending latch contributes to its bank's request line. The interrupt controller downstream sees only the four bank requests. When it services a bank, it pulses that bank's clear strobe, and this empties every pending latch in the bank.

Software can reach only the four mask registers, through a small synchronous write / combinational read bus. Pending state cannot be read. The lines are sampled the same way whatever the direction of the underlying port pins, so the block has no direction input. The latency is fixed: a falling edge on a pin shows on its bank request after the third rising clock edge.

Top module: `edge_wake_groups`

## Requirements
- R1: After reset every mask bit is 1, including bank 0 bit 6. Every pending latch is empty and all four request outputs are 0.
- R2: A falling edge on an unmasked line raises its bank request after the third rising clock edge that follows the pin change.
- R3: A rising edge, or a line held steadily low or high, never raises a request.
- R4: A set mask bit keeps its line off the bank request. An edge that arrives while the line is masked is still latched, and the request appears in the cycle after that bit is cleared to 0.
- R5: A clear strobe on bank g empties only bank g's pending latches. The request of every other bank is unchanged.
- R6: If a clear strobe and a new falling edge reach the same line's latch on the same clock edge, the latch stays set and the request stays high.
- R7: Register address g (0..3) selects the mask of bank g. Bit b of that register masks pin_i[8*g+b]. A write updates only the addressed register, and a read returns its current value on the next cycle.
- R8: Once raised, a bank request stays high until that bank is cleared or the line is masked, even after the pin returns high.
- R9: Pins 8*g to 8*g+7 drive request bit g and no other request bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 32 | Line levels; bank g is bits 8*g+7..8*g |
| reg_wr_en | input | 1 | Mask register write strobe |
| reg_addr | input | 2 | Mask register index, equal to the bank number |
| reg_wdata | input | 8 | Mask write data; 1 masks the line |
| reg_rdata | output | 8 | Mask of the addressed bank |
| grp_clr_i | input | 4 | Per-bank clear strobe from the interrupt controller |
| grp_req_o | output | 4 | Per-bank interrupt request |

## Verification
The checker watches four things on every cycle: that the requests are quiet right after reset, that no request rises without a pin fall or a mask write at the right distance in the past, that a clear without a coinciding fall drops the bank request, and that a raised request holds. It also checks on every cycle that mask writes read back. The directed scenarios have to show the parts that depend on mask contents the checker does not track. These are: a latched edge surfacing on unmask, the set-over-clear collision, isolation between banks under clear, and that each line reaches its own bank only.

// File: rtl/ewg_pkg.sv
package ewg_pkg;
   function automatic int unsigned ewg_idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/ewg_sync.sv
module ewg_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ewg_line_latch.sv
module ewg_line_latch #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   input  logic         clr_i,
   output logic [W-1:0] pend_o
);
   logic [W-1:0] prev_q;
   logic [W-1:0] pend_q;
   logic [W-1:0] fall;

   assign fall = prev_q & ~lvl_i;

   for (genvar b = 0; b < W; b++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[b] <= 1'b0;
            pend_q[b] <= 1'b0;
         end else begin
            prev_q[b] <= lvl_i[b];
            if (fall[b])     pend_q[b] <= 1'b1;
            else if (clr_i)  pend_q[b] <= 1'b0;
         end
      end
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/ewg_mask_bank.sv
module ewg_mask_bank #(
   parameter int unsigned             GROUPS = 4,
   parameter int unsigned             W      = 8,
   parameter int unsigned             AW     = 2,
   parameter logic [GROUPS*W-1:0]     RST    = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en_i,
   input  logic [AW-1:0]       addr_i,
   input  logic [W-1:0]        wdata_i,
   output logic [W-1:0]        rdata_o,
   output logic [GROUPS*W-1:0] mask_o
);
   logic [W-1:0] mask_q [GROUPS];

   for (genvar g = 0; g < GROUPS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  mask_q[g] <= RST[g*W +: W];
         else if (wr_en_i && (int'(addr_i) == g))     mask_q[g] <= wdata_i;
      end
      assign mask_o[g*W +: W] = mask_q[g];
   end

   always_comb begin
      rdata_o = '0;
      for (int g = 0; g < GROUPS; g++) begin
         if (int'(addr_i) == g) rdata_o = mask_q[g];
      end
   end
endmodule

// File: rtl/edge_wake_groups.sv
module edge_wake_groups
   import ewg_pkg::*;
#(
   parameter int unsigned GROUPS        = 4,
   parameter int unsigned LINES_PER_GRP = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter logic [GROUPS*LINES_PER_GRP-1:0] MASK_RST = '1,
   localparam int unsigned NLINES = GROUPS * LINES_PER_GRP,
   localparam int unsigned AW     = ewg_idx_w(GROUPS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NLINES-1:0]        pin_i,
   input  logic                     reg_wr_en,
   input  logic [AW-1:0]            reg_addr,
   input  logic [LINES_PER_GRP-1:0] reg_wdata,
   output logic [LINES_PER_GRP-1:0] reg_rdata,
   input  logic [GROUPS-1:0]        grp_clr_i,
   output logic [GROUPS-1:0]        grp_req_o
);
   if (GROUPS < 1) begin : g_bad_groups
      $error("GROUPS must be at least 1");
   end
   if (LINES_PER_GRP < 1) begin : g_bad_lines
      $error("LINES_PER_GRP must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NLINES-1:0] lvl;
   logic [NLINES-1:0] mask;
   logic [NLINES-1:0] pend;

   ewg_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (lvl)
   );

   ewg_mask_bank #(
      .GROUPS (GROUPS),
      .W      (LINES_PER_GRP),
      .AW     (AW),
      .RST    (MASK_RST)
   ) mask_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (reg_wr_en),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata),
      .rdata_o (reg_rdata),
      .mask_o  (mask)
   );

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      ewg_line_latch #(.W(LINES_PER_GRP)) latch_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .lvl_i  (lvl[g*LINES_PER_GRP +: LINES_PER_GRP]),
         .clr_i  (grp_clr_i[g]),
         .pend_o (pend[g*LINES_PER_GRP +: LINES_PER_GRP])
      );
      assign grp_req_o[g] = |(pend[g*LINES_PER_GRP +: LINES_PER_GRP]
                              & ~mask[g*LINES_PER_GRP +: LINES_PER_GRP]);
   end
endmodule

// File: rtl/edge_wake_groups_chk.sv
module edge_wake_groups_chk #(
   parameter int unsigned GROUPS = 4,
   parameter int unsigned LW     = 8,
   parameter int unsigned AW     = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [GROUPS*LW-1:0] pin_i,
   input logic                 reg_wr_en,
   input logic [AW-1:0]        reg_addr,
   input logic [LW-1:0]        reg_wdata,
   input logic [LW-1:0]        reg_rdata,
   input logic [GROUPS-1:0]    grp_clr_i,
   input logic [GROUPS-1:0]    grp_req_o
);
   // R1
   req_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (grp_req_o == '0));

   // R7
   mask_wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> ((reg_addr != $past(reg_addr)) || (reg_rdata == $past(reg_wdata))));

   for (genvar g = 0; g < GROUPS; g++) begin : g_chk
      // R3
      no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(grp_req_o[g]) |-> ($past(reg_wr_en) ||
            (|($past(pin_i[g*LW +: LW], 4) & ~$past(pin_i[g*LW +: LW], 3)))));

      // R5
      clr_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_clr_i[g] && !(|($past(pin_i[g*LW +: LW], 3) & ~$past(pin_i[g*LW +: LW], 2))))
         |=> !grp_req_o[g]);

      // R8
      req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_req_o[g] && !grp_clr_i[g] && !reg_wr_en) |=> grp_req_o[g]);
   end
endmodule

bind edge_wake_groups edge_wake_groups_chk #(
   .GROUPS (GROUPS),
   .LW     (LINES_PER_GRP),
   .AW     (AW)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .pin_i     (pin_i),
   .reg_wr_en (reg_wr_en),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .grp_clr_i (grp_clr_i),
   .grp_req_o (grp_req_o)
);

// File: tb/edge_wake_groups_tb_top.sv
`timescale 1ns/1ps
module edge_wake_groups_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pin_i = '1;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [3:0]  grp_clr_i = '0;
   logic [3:0]  grp_req_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   edge_wake_groups dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin_i),
      .reg_wr_en (reg_wr_en),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .grp_clr_i (grp_clr_i),
      .grp_req_o (grp_req_o)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_mask(input logic [1:0] a, input logic [7:0] d);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      step(1);
      reg_wr_en = 1'b0;
   endtask

   task automatic clear_banks(input logic [3:0] m);
      grp_clr_i = m;
      step(1);
      grp_clr_i = '0;
   endtask

   task automatic idle_all;
      pin_i = '1;
      step(4);
      clear_banks(4'hF);
      step(1);
   endtask

   task automatic t_reset;
      step(1);
      check("R1 req after reset", {28'd0, grp_req_o}, 32'h0);
      for (int a = 0; a < 4; a++) begin
         reg_addr = 2'(a);
         step(1);
         check("R1 mask reset value", {24'd0, reg_rdata}, 32'hFF);
      end
   endtask

   task automatic t_regs;
      wr_mask(2'd1, 8'h5A);
      reg_addr = 2'd1; step(1);
      check("R7 readback addr1", {24'd0, reg_rdata}, 32'h5A);
      reg_addr = 2'd0; step(1);
      check("R7 addr0 untouched", {24'd0, reg_rdata}, 32'hFF);
      reg_addr = 2'd2; step(1);
      check("R7 addr2 untouched", {24'd0, reg_rdata}, 32'hFF);
      for (int a = 0; a < 4; a++) wr_mask(2'(a), 8'h00);
      reg_addr = 2'd3; step(1);
      check("R7 addr3 cleared", {24'd0, reg_rdata}, 32'h00);
   endtask

   task automatic t_basic;
      pin_i[27] = 1'b0;
      step(2);
      check("R2 no req before third edge", {28'd0, grp_req_o}, 32'h0);
      step(1);
      check("R9 pin27 to bank3 only", {28'd0, grp_req_o}, 32'h8);
      idle_all();
      pin_i[4] = 1'b0;
      step(3);
      check("R2 pin4 to bank0", {28'd0, grp_req_o}, 32'h1);
      idle_all();
   endtask

   task automatic t_no_trigger;
      pin_i[20] = 1'b0;
      step(4);
      clear_banks(4'h4);
      step(5);
      check("R3 steady low no req", {28'd0, grp_req_o}, 32'h0);
      pin_i[20] = 1'b1;
      step(5);
      check("R3 rising no req", {28'd0, grp_req_o}, 32'h0);
   endtask

   task automatic t_mask;
      wr_mask(2'd1, 8'h08);
      pin_i[11] = 1'b0;
      step(4);
      check("R4 masked line silent", {28'd0, grp_req_o}, 32'h0);
      pin_i[11] = 1'b1;
      step(3);
      wr_mask(2'd1, 8'h00);
      check("R4 latched edge after unmask", {28'd0, grp_req_o}, 32'h2);
      idle_all();
   endtask

   task automatic t_clear;
      pin_i[2] = 1'b0; pin_i[17] = 1'b0;
      step(3);
      check("R5 two banks pending", {28'd0, grp_req_o}, 32'h5);
      clear_banks(4'h1);
      check("R5 only bank0 cleared", {28'd0, grp_req_o}, 32'h4);
      idle_all();
   endtask

   task automatic t_set_wins;
      pin_i[30] = 1'b0;
      step(2);
      grp_clr_i = 4'h8;
      step(1);
      grp_clr_i = '0;
      check("R6 set beats clear", {28'd0, grp_req_o}, 32'h8);
      idle_all();
   endtask

   task automatic t_hold;
      pin_i[9] = 1'b0;
      step(3);
      pin_i[9] = 1'b1;
      step(10);
      check("R8 request held", {28'd0, grp_req_o}, 32'h2);
      clear_banks(4'h2);
      check("R8 released by clear", {28'd0, grp_req_o}, 32'h0);
      idle_all();
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(4);
      t_reset();
      t_regs();
      t_basic();
      t_no_trigger();
      t_mask();
      t_clear();
      t_set_wins();
      t_hold();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule